// File: doc/BRIEF.md
# Grouped External Interrupt Hub

This block watches 28 external request pins, already synchronous to its clock. Each pin has a trigger condition: a level or an edge. When a pin meets its condition, the block latches a pending flag for that line. Every line also has a mask flag. Unmasked pending flags are OR-reduced into four group request lines for a parent vectored interrupt controller. The four groups are unequal: lines 0–3, 4–11, 12–19 and 20–27.

Software talks to the block over a simple register port: address, write data, write strobe and read data. Reads are combinational, and writes take effect at the next clock edge.

The trigger fields are held per pair of lines. Adjacent lines 2k and 2k+1 always share the same condition. The handler in software reads the pending and mask registers to find the line that fired. It then clears that line by writing a one to its pending bit. A level-triggered source keeps re-asserting its pending bit for as long as its level stays active.

Top module: `extirq_hub`

## Requirements
- R1: After reset every mask bit is 1, every pending bit is 0, every trigger field is 000, and the internal pin history holds all ones, so that no low-level event fires before a pin is sampled.
- R2: Register offsets are 0x00 for the trigger word of lines 0–15, 0x04 for the trigger word of lines 16–27, 0x08 for mask and 0x0C for pending. In a trigger word, the 3-bit field of line n sits at bits [((n mod 16)/2)*4 +: 3] and is shared with its pair partner. Bit 3 of each nibble, the bits above the last field, bits 31:28 of mask and pending, and reads of any other address all return 0. Writes to any other address change nothing.
- R3: Trigger code 000 selects low level and 001 selects high level. A pin value present before clock edge k is sampled at edge k. If that sample is active, the pending bit is set at edge k+1, and it is set again on every edge while the sample stays active.
- R4: Codes 010/011 select falling edge, 100/101 rising edge and 110/111 both edges. An edge between the samples taken at edges k-1 and k sets the pending bit at edge k+1, once per edge. A pending bit is never set by anything else.
- R5: Writing 0x08 loads the mask from bits 27:0. A 1 masks a line and a 0 enables it.
- R6: Writing 0x0C clears each pending bit whose write-data bit is 1 at that edge. Bits written with 0 are left unchanged.
- R7: A masked line still sets its pending bit. Its mask only hides it from its group output.
- R8: When a clear and a trigger event for the same line meet at one edge, the line stays pending.
- R9: Group output g is 1 exactly when some line in its range (g0: 0–3, g1: 4–11, g2: 12–19, g3: 20–27) is pending and unmasked. The output follows the registers with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pins | input | 28 | External request pins, synchronous to clk |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Write strobe, acted on at the clock edge |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| grp_irq | output | 4 | Group interrupt requests to the parent controller |

## Verification
A pin change is due in the pending register two edges after it is driven: one edge to sample it and one to latch it. A register write shows up one edge after the strobe. Read data and group outputs are combinational from the registers.

The bench drives every input just after a falling edge. It advances a behavioural reference model on the rising edge, so the model sees the same inputs the design does. At the next falling edge it compares the read data and all four group outputs against the model. In this way every check lands after all of the register stages on the path have settled.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int NUM_LINES     = 28;
    localparam int NUM_GROUPS    = 4;
    localparam int MODE_W        = 3;
    localparam int NUM_PAIRS     = NUM_LINES / 2;
    localparam int PAIRS_PER_REG = 8;
    localparam int HI_PAIRS      = NUM_PAIRS - PAIRS_PER_REG;
    localparam int FIELD_STRIDE  = 4;
    localparam int ADDR_W        = 8;
    localparam int DATA_W        = 32;

    localparam logic [ADDR_W-1:0] OFS_TRIG_LO = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_TRIG_HI = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PEND    = 8'h0C;

    typedef logic [NUM_PAIRS-1:0][MODE_W-1:0] mode_vec_t;

    typedef struct packed {
        logic [NUM_LINES-1:0] pin;
        logic [NUM_LINES-1:0] prev;
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] pend;
        mode_vec_t            mode;
    } hub_state_t;

    function automatic int grp_first(input int g);
        case (g)
            0:       return 0;
            1:       return 4;
            2:       return 12;
            default: return 20;
        endcase
    endfunction

    function automatic int grp_last(input int g);
        case (g)
            0:       return 3;
            1:       return 11;
            2:       return 19;
            default: return 27;
        endcase
    endfunction

    function automatic logic trig_hit(input logic [MODE_W-1:0] m,
                                      input logic cur, input logic prv);
        case (m[2:1])
            2'b00:   return m[0] ? cur : ~cur;
            2'b01:   return prv & ~cur;
            2'b10:   return ~prv & cur;
            default: return prv ^ cur;
        endcase
    endfunction

endpackage

// File: rtl/extirq_detect.sv
module extirq_detect
    import extirq_pkg::*;
#(
    parameter int LINES = NUM_LINES
) (
    input  logic [LINES-1:0]   cur,
    input  logic [LINES-1:0]   prev,
    input  mode_vec_t          mode,
    output logic [LINES-1:0]   evt
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign evt[i] = trig_hit(mode[i/2], cur[i], prev[i]);
    end
endmodule

// File: rtl/extirq_group_or.sv
module extirq_group_or
    import extirq_pkg::*;
(
    input  logic [NUM_LINES-1:0]  pend,
    input  logic [NUM_LINES-1:0]  mask,
    output logic [NUM_GROUPS-1:0] grp
);
    logic [NUM_LINES-1:0] live;
    assign live = pend & ~mask;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int LO = grp_first(g);
        localparam int HI = grp_last(g);
        assign grp[g] = |live[HI:LO];
    end
endmodule

// File: rtl/extirq_readmux.sv
module extirq_readmux
    import extirq_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  mode_vec_t            mode,
    input  logic [NUM_LINES-1:0] mask,
    input  logic [NUM_LINES-1:0] pend,
    output logic [DATA_W-1:0]    rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_TRIG_LO: begin
                for (int p = 0; p < PAIRS_PER_REG; p++)
                    rdata[p*FIELD_STRIDE +: MODE_W] = mode[p];
            end
            OFS_TRIG_HI: begin
                for (int p = 0; p < HI_PAIRS; p++)
                    rdata[p*FIELD_STRIDE +: MODE_W] = mode[PAIRS_PER_REG + p];
            end
            OFS_MASK: rdata[NUM_LINES-1:0] = mask;
            OFS_PEND: rdata[NUM_LINES-1:0] = pend;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/extirq_hub.sv
module extirq_hub
    import extirq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   ext_pins,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic                   bus_we,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic [NUM_GROUPS-1:0]  grp_irq
);
    hub_state_t st_d, st_q;

    logic [NUM_LINES-1:0] evt;
    logic [NUM_LINES-1:0] clr;
    logic [NUM_LINES-1:0] pend_vec;
    logic [NUM_LINES-1:0] mask_vec;
    logic                 unused_wdata;

    assign pend_vec     = st_q.pend;
    assign mask_vec     = st_q.mask;
    assign unused_wdata = ^bus_wdata;

    extirq_detect #(.LINES(NUM_LINES)) u_detect (
        .cur  (st_q.pin),
        .prev (st_q.prev),
        .mode (st_q.mode),
        .evt  (evt)
    );

    extirq_group_or u_group (
        .pend (pend_vec),
        .mask (mask_vec),
        .grp  (grp_irq)
    );

    extirq_readmux u_read (
        .addr  (bus_addr),
        .mode  (st_q.mode),
        .mask  (mask_vec),
        .pend  (pend_vec),
        .rdata (bus_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pin  = ext_pins;
        st_d.prev = st_q.pin;

        clr = (bus_we && bus_addr == OFS_PEND) ? bus_wdata[NUM_LINES-1:0] : '0;
        // events are applied after the clear, so a same-edge event survives
        st_d.pend = (st_q.pend & ~clr) | evt;

        if (bus_we) begin
            case (bus_addr)
                OFS_MASK: st_d.mask = bus_wdata[NUM_LINES-1:0];
                OFS_TRIG_LO: begin
                    for (int p = 0; p < PAIRS_PER_REG; p++)
                        st_d.mode[p] = bus_wdata[p*FIELD_STRIDE +: MODE_W];
                end
                OFS_TRIG_HI: begin
                    for (int p = 0; p < HI_PAIRS; p++)
                        st_d.mode[PAIRS_PER_REG + p] = bus_wdata[p*FIELD_STRIDE +: MODE_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pin  <= '1;
            st_q.prev <= '1;
            st_q.mask <= '1;
            st_q.pend <= '0;
            st_q.mode <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/extirq_hub_chk.sv
module extirq_hub_chk
    import extirq_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic                  bus_we,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [NUM_GROUPS-1:0] grp_irq,
    input logic [NUM_LINES-1:0]  pend,
    input logic [NUM_LINES-1:0]  mask,
    input logic [NUM_LINES-1:0]  evt
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assert_evt_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> pend[i])
            else $error("line %0d event lost", i);

        assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == OFS_PEND && bus_wdata[i] && !evt[i]) |=> !pend[i])
            else $error("line %0d not cleared", i);

        assert_pend_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) |-> $past(evt[i]))
            else $error("line %0d pending without event", i);
    end

    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_MASK) |=> mask == $past(bus_wdata[NUM_LINES-1:0]))
        else $error("mask write not taken");

    assert_rdata_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_MASK || bus_addr == OFS_PEND) |-> bus_rdata[DATA_W-1:NUM_LINES] == '0)
        else $error("unused read bits set");

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int LO = grp_first(g);
        localparam int HI = grp_last(g);
        assert_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq[g] == |(pend[HI:LO] & ~mask[HI:LO]))
            else $error("group %0d output wrong", g);
    end
endmodule

bind extirq_hub extirq_hub_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .grp_irq   (grp_irq),
    .pend      (pend_vec),
    .mask      (mask_vec),
    .evt       (evt)
);

// File: tb/extirq_hub_test.sv
module extirq_hub_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [27:0] ext_pins;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic [31:0] bus_rdata;
    logic [3:0]  grp_irq;

    int    n_vec  = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    // behavioural reference state
    int mtrig [28];
    bit mpin  [28];
    bit mprev [28];
    bit mmask [28];
    bit mpend [28];

    always #(CLK_PERIOD/2) clk = ~clk;

    extirq_hub uut (
        .clk(clk), .rst_n(rst_n), .ext_pins(ext_pins), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .grp_irq(grp_irq)
    );

    function automatic bit m_event(int mode, bit cur, bit prv);
        if (mode == 0) return !cur;
        if (mode == 1) return cur;
        if (mode <= 3) return prv && !cur;
        if (mode <= 5) return !prv && cur;
        return prv != cur;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        logic [31:0] v = 0;
        if (a == 8'h00) for (int k = 0; k < 8; k++) v |= 32'(mtrig[2*k]) << (4*k);
        else if (a == 8'h04) for (int k = 0; k < 6; k++) v |= 32'(mtrig[16+2*k]) << (4*k);
        else if (a == 8'h08) for (int i = 0; i < 28; i++) v[i] = mmask[i];
        else if (a == 8'h0C) for (int i = 0; i < 28; i++) v[i] = mpend[i];
        return v;
    endfunction

    function automatic logic [3:0] m_groups();
        int lo [4] = '{0, 4, 12, 20};
        int hi [4] = '{3, 11, 19, 27};
        logic [3:0] r = 0;
        for (int g = 0; g < 4; g++)
            for (int i = lo[g]; i <= hi[g]; i++)
                if (mpend[i] && !mmask[i]) r[g] = 1'b1;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 28; i++) begin
                mtrig[i] = 0; mpin[i] = 1; mprev[i] = 1; mmask[i] = 1; mpend[i] = 0;
            end
        end else begin : upd
            bit ev [28];
            for (int i = 0; i < 28; i++) ev[i] = m_event(mtrig[i], mpin[i], mprev[i]);
            for (int i = 0; i < 28; i++) begin
                if (bus_we && bus_addr == 8'h0C && bus_wdata[i]) mpend[i] = 0;
                if (ev[i]) mpend[i] = 1;
            end
            if (bus_we && bus_addr == 8'h08)
                for (int i = 0; i < 28; i++) mmask[i] = bus_wdata[i];
            if (bus_we && bus_addr == 8'h00)
                for (int i = 0; i < 16; i++) mtrig[i] = int'((bus_wdata >> ((i/2)*4)) & 32'h7);
            if (bus_we && bus_addr == 8'h04)
                for (int i = 16; i < 28; i++) mtrig[i] = int'((bus_wdata >> (((i-16)/2)*4)) & 32'h7);
            for (int i = 0; i < 28; i++) begin
                mprev[i] = mpin[i];
                mpin[i]  = ext_pins[i];
            end
        end
    end

    task automatic compare();
        logic [31:0] er = m_read(bus_addr);
        logic [3:0]  eg = m_groups();
        n_vec++;
        if (bus_rdata !== er || grp_irq !== eg) begin
            n_fail++;
            if (bus_rdata !== er)
                $display("FAIL %s rdata addr=%h actual=%h expected=%h", cur_req, bus_addr, bus_rdata, er);
            if (grp_irq !== eg)
                $display("FAIL %s grp_irq actual=%b expected=%b", cur_req, grp_irq, eg);
        end
    endtask

    task automatic apply(logic [7:0] a, logic [31:0] d, logic w, logic [27:0] p);
        bus_addr = a; bus_wdata = d; bus_we = w; ext_pins = p;
        @(negedge clk);
        compare();
    endtask

    function automatic logic [7:0] rnd_addr();
        case ($urandom % 5)
            0: return 8'h00;
            1: return 8'h04;
            2: return 8'h08;
            3: return 8'h0C;
            default: return 8'h10;
        endcase
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired during %s", cur_req);
        summary();
        $finish;
    end

    initial begin
        logic [27:0] p;
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0; ext_pins = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values through the register port
        cur_req = "R1";
        apply(8'h00, 0, 0, '1);
        apply(8'h04, 0, 0, '1);
        apply(8'h08, 0, 0, '1);
        apply(8'h0C, 0, 0, '1);

        // R2: field placement, reserved bits, unmapped addresses
        cur_req = "R2";
        apply(8'h00, '1, 1, '1); apply(8'h00, 0, 0, '1);
        apply(8'h04, '1, 1, '1); apply(8'h04, 0, 0, '1);
        apply(8'h10, '1, 1, '1); apply(8'h10, 0, 0, '1);
        apply(8'h08, 0, 0, '1);  apply(8'h0C, 0, 0, '1);
        apply(8'h00, 32'h1234_5678, 1, '1); apply(8'h00, 0, 0, '1);
        apply(8'h04, 32'h89AB_CDEF, 1, '1); apply(8'h04, 0, 0, '1);

        // R3: high level then low level, clear while level persists
        cur_req = "R3";
        apply(8'h00, 32'h1111_1111, 1, '1);
        apply(8'h04, 32'h0011_1111, 1, '1);
        apply(8'h08, 32'h0, 1, '1);
        for (int k = 0; k < 4; k++) apply(8'h0C, '1, 1, '1);
        for (int k = 0; k < 4; k++) apply(8'h0C, '1, 1, '0);
        apply(8'h0C, 0, 0, '0);
        apply(8'h00, 32'h0, 1, '0);
        apply(8'h04, 32'h0, 1, 28'h00F_00F0);
        for (int k = 0; k < 4; k++) apply(8'h0C, '1, 1, 28'h00F_00F0);
        apply(8'h0C, 0, 0, '1);

        // R4: edge codes with both values of the low bit
        cur_req = "R4";
        apply(8'h00, 32'h4276_5432, 1, '1);
        apply(8'h04, 32'h0035_7246, 1, '1);
        apply(8'h0C, '1, 1, '1);
        for (int k = 0; k < 200; k++) begin
            p = 28'($urandom);
            if (k % 2 == 0) apply(8'h0C, '1, 1, p);
            else            apply(8'h0C, 0, 0, p);
        end

        // R5: mask loads
        cur_req = "R5";
        for (int k = 0; k < 100; k++) begin
            p = 28'($urandom);
            if (k % 3 == 0)      apply(8'h08, $urandom, 1, p);
            else if (k % 3 == 1) apply(8'h08, 0, 0, p);
            else                 apply(8'h0C, 0, 0, p);
        end

        // R6: zero bits leave pending untouched, one bits clear
        cur_req = "R6";
        apply(8'h0C, 0, 0, '1);
        for (int k = 0; k < 3; k++) apply(8'h0C, 0, 1, '1);
        apply(8'h0C, 32'h0F0F_0F0F, 1, '1);
        apply(8'h0C, 0, 0, '1);
        apply(8'h0C, '1, 1, '1);
        apply(8'h0C, 0, 0, '1);

        // R7: masked lines still record events
        cur_req = "R7";
        apply(8'h08, '1, 1, '1);
        for (int k = 0; k < 20; k++) apply(8'h0C, 0, 0, (k % 2) ? '1 : '0);

        // R8: clear strobe held while edges arrive
        cur_req = "R8";
        apply(8'h08, 0, 1, '1);
        apply(8'h0C, '1, 1, '1);
        for (int k = 0; k < 12; k++) apply(8'h0C, '1, 1, (k % 3 == 0) ? 28'h0 : 28'hFFF_FFFF);
        apply(8'h0C, 0, 0, '1);

        // R9: mixed traffic on all groups
        cur_req = "R9";
        for (int k = 0; k < 1500; k++) begin
            logic [7:0] a = rnd_addr();
            apply(a, $urandom, ($urandom % 4) == 0, 28'($urandom));
        end

        summary();
        $finish;
    end
endmodule